// File: doc/BRIEF.md
# Cyclic Lookup Sweeper with Ones/Zeros Balance Flag

This block holds a fixed 16-entry table of 4-bit words, where entry i contains the value i. Driven by one clock, it walks the table without end, wrapping from the last entry back to entry 0. A mode input chooses how the table is presented.

In parallel mode, one whole word appears on `word_out` on every cycle. A balance flag reports whether that word has exactly as many set bits as clear ones. In serial mode, one bit appears on `bit_out` on every cycle. The bits of each word come out least significant first, and the address moves on only after the top bit. A running count of ones is resolved into the balance flag on the cycle that completes each word.

A one-cycle `valid_out` strobe marks every cycle on which the balance flag was just updated. When the mode input changes, the sweep restarts from entry 0, bit 0, with a cleared count.

Top module: `rom_sweep_balance`

## Requirements
- R1: While `rst` is high at a clock edge, `word_out`, `bit_out`, `balance_out` and `valid_out` become 0. The first cycle after release reads entry 0 (bit 0 in serial mode).
- R2: Table entry i holds the 4-bit value i, for i = 0 to 15.
- R3: With `serial_mode` = 0, each clock edge places the current entry on `word_out` and then advances the address by one, wrapping from 15 to 0.
- R4: With `serial_mode` = 0, every edge sets `balance_out` to 1 exactly when the word just placed has two of its four bits set, and drives `valid_out` to 1.
- R5: With `serial_mode` = 1, each edge places one bit of the current entry on `bit_out`, in the order bit 0, 1, 2, 3. After bit 3 the address advances, wrapping from 15 to 0.
- R6: In serial mode, `balance_out` changes only on the edge that emits bit 3 of a word. It is then set to 1 exactly when that word's four bits held two ones. On all other edges it holds.
- R7: In serial mode, `valid_out` is 1 only after the edge that emits bit 3 of a word, which is one cycle in four.
- R8: On the first edge at which `serial_mode` differs from its value at the previous edge, `valid_out` goes to 0 and the other outputs hold. Address, bit index and ones count clear, so the next edge reads entry 0, bit 0, and a word's balance never includes bits from before the change.
- R9: In serial mode `word_out` holds its value; in parallel mode `bit_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 0 = one word per cycle, 1 = one bit per cycle |
| word_out | output | 4 | Registered word read in parallel mode |
| bit_out | output | 1 | Registered bit read in serial mode |
| balance_out | output | 1 | 1 when the last judged word had two ones |
| valid_out | output | 1 | One-cycle strobe: balance_out just updated |

## Verification
A wrong address shows in parallel mode on the next cycle, as a `word_out` value that breaks the count sequence. In serial mode it shows within four cycles, as a wrong bit pattern or a balance verdict for the wrong word. A wrong bit index or an uncleared ones count is invisible on `bit_out` for up to three cycles, then appears as a misplaced `valid_out` strobe or a wrong `balance_out` at the end of the word. The bench switches mode in the middle of a word so that a count left over from before the switch would corrupt the verdict on a balanced word (value 3) read afterwards.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  typedef enum logic {
    MODE_PARALLEL = 1'b0,
    MODE_SERIAL   = 1'b1
  } sweep_mode_e;

  function automatic int ones_in(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/rsb_rom.sv
module rsb_rom #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] table_w [DEPTH];

  // R2: each entry carries its own index
  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign table_w[g] = WORD_W'(g);
  end

  assign rd_word = table_w[addr];

endmodule

// File: rtl/rsb_sequencer.sv
module rsb_sequencer
  import rsb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_mode,
  output logic [ADDR_W-1:0] addr,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              last_bit,
  output logic              restart
);

  sweep_mode_e       mode_q;
  sweep_mode_e       mode_now;
  logic [ADDR_W-1:0] addr_inc;

  assign mode_now = sweep_mode_e'(serial_mode);
  assign restart  = (mode_now != mode_q);
  assign last_bit = (bit_idx == BIT_W'(WORD_W - 1));
  assign addr_inc = (addr == ADDR_W'(DEPTH - 1)) ? '0 : addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      bit_idx <= '0;
      mode_q  <= mode_now;
    end else if (restart) begin
      addr    <= '0;
      bit_idx <= '0;
      mode_q  <= mode_now;
    end else if (mode_now == MODE_PARALLEL) begin
      addr    <= addr_inc;
      bit_idx <= '0;
    end else if (last_bit) begin
      addr    <= addr_inc;
      bit_idx <= '0;
    end else begin
      bit_idx <= bit_idx + BIT_W'(1);
    end
  end

  assert_par_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!serial_mode && !restart) |=>
      addr == (($past(addr) == ADDR_W'(DEPTH - 1)) ? '0 : $past(addr) + ADDR_W'(1)));

  assert_ser_hold_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (serial_mode && !restart && !last_bit) |=> $stable(addr));

  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (addr == '0 && bit_idx == '0));

endmodule

// File: rtl/rsb_judge.sv
module rsb_judge
  import rsb_pkg::*;
#(
  parameter int WORD_W = 4,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_mode,
  input  logic              restart,
  input  logic              last_bit,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] word_out,
  output logic              bit_out,
  output logic              balance_out,
  output logic              valid_out
);

  logic [CNT_W-1:0] ones_cnt;
  logic [CNT_W-1:0] cnt_next;
  logic             cur_bit;
  logic             word_even;

  assign cur_bit   = rd_word[bit_idx];
  assign cnt_next  = ones_cnt + CNT_W'(cur_bit);
  assign word_even = (ones_in(32'(rd_word)) == WORD_W / 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out    <= '0;
      bit_out     <= 1'b0;
      balance_out <= 1'b0;
      valid_out   <= 1'b0;
      ones_cnt    <= '0;
    end else if (restart) begin
      valid_out   <= 1'b0;
      ones_cnt    <= '0;
    end else if (sweep_mode_e'(serial_mode) == MODE_PARALLEL) begin
      word_out    <= rd_word;
      balance_out <= word_even;
      valid_out   <= 1'b1;
      ones_cnt    <= '0;
    end else begin
      bit_out <= cur_bit;
      if (last_bit) begin
        balance_out <= (cnt_next == CNT_W'(WORD_W / 2));
        valid_out   <= 1'b1;
        ones_cnt    <= '0;
      end else begin
        valid_out   <= 1'b0;
        ones_cnt    <= cnt_next;
      end
    end
  end

  assert_par_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (!serial_mode && !restart) |=> valid_out);

  assert_bal_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (serial_mode && !last_bit) |=> $stable(balance_out));

  assert_ser_strobe_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (serial_mode && !restart && valid_out) |=> !valid_out);

  assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
    serial_mode |=> $stable(word_out));

endmodule

// File: rtl/rom_sweep_balance.sv
module rom_sweep_balance #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_mode,
  output logic [WORD_W-1:0] word_out,
  output logic              bit_out,
  output logic              balance_out,
  output logic              valid_out
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BIT_W  = $clog2(WORD_W);

  logic [ADDR_W-1:0] addr;
  logic [BIT_W-1:0]  bit_idx;
  logic              last_bit;
  logic              restart;
  logic [WORD_W-1:0] rd_word;

  rsb_sequencer #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst(rst), .serial_mode(serial_mode),
    .addr(addr), .bit_idx(bit_idx), .last_bit(last_bit), .restart(restart)
  );

  rsb_rom #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_rom (
    .addr(addr), .rd_word(rd_word)
  );

  rsb_judge #(.WORD_W(WORD_W)) u_judge (
    .clk(clk), .rst(rst), .serial_mode(serial_mode), .restart(restart),
    .last_bit(last_bit), .bit_idx(bit_idx), .rd_word(rd_word),
    .word_out(word_out), .bit_out(bit_out),
    .balance_out(balance_out), .valid_out(valid_out)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!valid_out && !balance_out && !bit_out && word_out == '0));

endmodule

// File: tb/rom_sweep_balance_tb.sv
module rom_sweep_balance_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serial_mode = 1'b0;
  logic [3:0] word_out;
  logic       bit_out, balance_out, valid_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // bench model, built from the requirements
  int m_addr = 0, m_bidx = 0;
  int e_word = 0, e_bit = 0, e_bal = 0, e_valid = 0;

  always #2 clk = ~clk;

  rom_sweep_balance u_dut (
    .clk(clk), .rst(rst), .serial_mode(serial_mode),
    .word_out(word_out), .bit_out(bit_out),
    .balance_out(balance_out), .valid_out(valid_out)
  );

  function automatic int pc4(input int v);
    return ((v >> 0) & 1) + ((v >> 1) & 1) + ((v >> 2) & 1) + ((v >> 3) & 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string tag);
    check({tag, " word_out"},    int'(word_out),    e_word);
    check({tag, " bit_out"},     int'(bit_out),     e_bit);
    check({tag, " balance_out"}, int'(balance_out), e_bal);
    check({tag, " valid_out"},   int'(valid_out),   e_valid);
  endtask

  task automatic t_reset_r1(input bit mode, input int cycles);
    rst = 1'b1;
    serial_mode = mode;
    for (int i = 0; i < cycles; i++) begin
      step();
      e_word = 0; e_bit = 0; e_bal = 0; e_valid = 0;
      m_addr = 0; m_bidx = 0;
      check_all("R1 reset");
    end
    rst = 1'b0;
  endtask

  task automatic t_parallel_r3(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      step();
      e_word  = m_addr;                       // R2: entry i holds i
      e_bal   = (pc4(m_addr) == 2) ? 1 : 0;   // R4
      e_valid = 1;
      m_addr  = (m_addr + 1) % 16;
      check("R2/R3 word_out", int'(word_out), e_word);
      check("R4 balance_out", int'(balance_out), e_bal);
      check("R4 valid_out", int'(valid_out), e_valid);
      check("R9 bit_out held", int'(bit_out), e_bit);
    end
  endtask

  task automatic t_serial_r5(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      step();
      e_bit = (m_addr >> m_bidx) & 1;
      if (m_bidx == 3) begin
        e_bal   = (pc4(m_addr) == 2) ? 1 : 0;
        e_valid = 1;
        m_bidx  = 0;
        m_addr  = (m_addr + 1) % 16;
      end else begin
        e_valid = 0;
        m_bidx++;
      end
      check("R5 bit_out", int'(bit_out), e_bit);
      check("R6 balance_out", int'(balance_out), e_bal);
      check("R7 valid_out", int'(valid_out), e_valid);
      check("R9 word_out held", int'(word_out), e_word);
    end
  endtask

  task automatic t_switch_r8(input bit new_mode);
    serial_mode = new_mode;
    step();
    e_valid = 0;
    m_addr = 0;
    m_bidx = 0;
    check_all("R8 switch");
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset_r1(1'b0, 3);
    t_parallel_r3(40);            // two and a half laps, wrap 15 -> 0
    t_switch_r8(1'b1);            // held word 7, balance 0
    t_serial_r5(72);              // 18 words, wraps past 15
    t_serial_r5(2);               // part of word 2
    t_switch_r8(1'b0);            // mid-word switch drops partial count
    t_switch_r8(1'b1);            // immediate switch back
    t_serial_r5(16);              // words 0..3, word 3 must judge balanced
    t_parallel_r3(0);
    t_switch_r8(1'b0);
    t_parallel_r3(5);
    t_serial_r5(0);
    t_switch_r8(1'b1);
    t_serial_r5(3);               // partial word before reset
    t_reset_r1(1'b1, 2);          // R1: reset in serial mode
    t_serial_r5(12);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule